// File: doc/BRIEF.md
# Host Command and Interrupt Register Block

This block is the small register file through which a host processor drives a descriptor-based network controller. The host reaches it over a plain byte-addressed bus. It holds four registers. An interrupt control byte (write only) carries per-event enables, a global mask and a software interrupt request. A command byte (write only) tells the transmit-side command unit and the receive unit what to do next. A status byte (read/write) collects events. A 32-bit general pointer (read/write) carries an address argument for those commands.

A write to the command byte does not change any stored state visible to the host. It is turned into a single-cycle strobe that carries two opcode fields, one for each unit. The units act on the strobe and take their address argument from the general pointer output. They report progress by pulsing event inputs, and each pulse sets one bit of the status byte. The host clears status bits by writing ones to them. A single registered, level-sensitive interrupt line is evaluated every cycle from the control and status contents, using a fixed priority.

Top module: `hcr_top`

## Requirements
- R1: After synchronous reset, the status byte, the pointer and the control byte are zero. The interrupt output, the command strobe and the read data are all low.
- R2: A write at offset 0x04 loads all 32 bits of the pointer. A read at offset 0x04 returns the pointer on `bus_rdata` in the cycle after `bus_rd`. In any cycle after one without a read, `bus_rdata` is zero.
- R3: A write at offset 0x01 raises `cmd_vld` for exactly the next cycle. In that cycle `cu_op` equals `bus_wdata[7:4]` and `ru_op` equals `bus_wdata[2:0]`. Bit 3 of the written byte is ignored.
- R4: A read at offset 0x02 returns the status byte in `bus_rdata[15:8]`, with every other bit zero.
- R5: A write at offset 0x02 clears each status bit whose matching bit in `bus_wdata[15:8]` is one. All other status bits are left unchanged.
- R6: A pulse on `evt_set[b]` sets status bit b, for b in {7,6,5,4,3,2,0}. The meanings are: 7 command finished, 6 frame received, 5 command unit left active, 4 receive unit left ready, 3 management cycle done, 2 software interrupt, 0 pause. Bit 1 is reserved and always reads zero.
- R7: An event pulse in the same cycle as a host clear of the same bit leaves the bit set.
- R8: While control bit 0 (global mask) is set, `irq` is low, whatever the other state.
- R9: While control bit 0 is clear and control bit 1 (software request) is set, `irq` is high.
- R10: Otherwise, `irq` is high exactly when some status bit in [7:4] is set and the control bit at the same position is clear. Status bits [3:0] and control bit 3 never raise `irq`.
- R11: `irq` is registered. It reflects the control and status contents one cycle later. A change on the bus or on an event input therefore reaches `irq` two clock edges after it is presented.
- R12: Writes to offsets other than 0x00, 0x01, 0x02 and 0x04 change nothing. Reads at any offset other than 0x02 and 0x04 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_set | input | 8 | Event pulses, one per status bit |
| irq | output | 1 | Level interrupt |
| cmd_vld | output | 1 | One-cycle command strobe |
| cu_op | output | 4 | Command-unit opcode |
| ru_op | output | 3 | Receive-unit opcode |
| gen_ptr | output | DATA_W | General pointer contents |

## Verification
The bound checker checks the interrupt priority on every cycle. It checks that the mask forces the line low, that the software request forces it high, and that the line follows the enabled upper status nibble. It also checks on every cycle that event pulses survive a same-cycle clear, that written-one bits clear, and that every command write gives a single strobe carrying its fields. The bench scenarios are needed for the rest: the exact readback layout of status and pointer, the reserved bit staying zero, unmapped offsets having no effect, and the two-edge latency from stimulus to interrupt.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int STAT_W = 8;

  // byte offsets on the host bus
  localparam int OFF_CTRL = 0;
  localparam int OFF_CMD  = 1;
  localparam int OFF_STAT = 2;
  localparam int OFF_PTR  = 4;

  // control byte bit positions
  localparam int CTL_GMASK = 0;
  localparam int CTL_SWREQ = 1;

  // status bits that raise the interrupt (upper nibble)
  localparam int EVT_HI = 7;
  localparam int EVT_LO = 4;

  // status bits that exist; bit 1 is reserved
  localparam logic [STAT_W-1:0] STAT_IMPL = 8'hFD;

  typedef struct packed {
    logic [3:0] cu;
    logic [2:0] ru;
  } cmd_t;
endpackage

// File: rtl/hcr_decode.sv
module hcr_decode
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_ctrl,
  output logic              wr_cmd,
  output logic              wr_stat,
  output logic              wr_ptr,
  output logic              rd_stat,
  output logic              rd_ptr
);
  logic hit_ctrl, hit_cmd, hit_stat, hit_ptr;

  always_comb begin
    hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
    hit_cmd  = (addr == ADDR_W'(OFF_CMD));
    hit_stat = (addr == ADDR_W'(OFF_STAT));
    hit_ptr  = (addr == ADDR_W'(OFF_PTR));
    wr_ctrl  = wr && hit_ctrl;
    wr_cmd   = wr && hit_cmd;
    wr_stat  = wr && hit_stat;
    wr_ptr   = wr && hit_ptr;
    rd_stat  = rd && hit_stat;
    rd_ptr   = rd && hit_ptr;
  end
endmodule

// File: rtl/hcr_status.sv
module hcr_status
  import hcr_pkg::*;
#(
  parameter int               W    = STAT_W,
  parameter logic [W-1:0]     IMPL = STAT_IMPL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_pulse,
  output logic [W-1:0] stat_q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)
          bit_q <= 1'b0;
        else if (set_pulse[b])
          bit_q <= 1'b1;              // a set outranks a same-cycle clear
        else if (clr_en && clr_mask[b])
          bit_q <= 1'b0;
      end
      assign stat_q[b] = bit_q;
    end else begin : g_rsvd
      assign stat_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/hcr_irq.sv
module hcr_irq
  import hcr_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ctrl,
  input  logic [W-1:0] stat,
  output logic         irq_q
);
  logic ev_hit;

  always_comb ev_hit = |(stat[EVT_HI:EVT_LO] & ~ctrl[EVT_HI:EVT_LO]);

  always_ff @(posedge clk) begin
    if (rst)                  irq_q <= 1'b0;
    else if (ctrl[CTL_GMASK]) irq_q <= 1'b0;
    else if (ctrl[CTL_SWREQ]) irq_q <= 1'b1;
    else                      irq_q <= ev_hit;
  end
endmodule

// File: rtl/hcr_top.sv
module hcr_top
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [STAT_W-1:0] evt_set,
  output logic              irq,
  output logic              cmd_vld,
  output logic [3:0]        cu_op,
  output logic [2:0]        ru_op,
  output logic [DATA_W-1:0] gen_ptr
);
  localparam int STAT_LSB = 8;
  localparam int STAT_MSB = STAT_LSB + STAT_W - 1;

  logic wr_ctrl, wr_cmd, wr_stat, wr_ptr, rd_stat, rd_ptr;
  logic [STAT_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  cmd_t              cmd_q;
  logic              vld_q;

  hcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_ctrl(wr_ctrl), .wr_cmd(wr_cmd), .wr_stat(wr_stat), .wr_ptr(wr_ptr),
    .rd_stat(rd_stat), .rd_ptr(rd_ptr)
  );

  hcr_status #(.W(STAT_W), .IMPL(STAT_IMPL)) u_stat (
    .clk(clk), .rst(rst),
    .clr_en(wr_stat), .clr_mask(bus_wdata[STAT_MSB:STAT_LSB]),
    .set_pulse(evt_set), .stat_q(stat_q)
  );

  hcr_irq #(.W(STAT_W)) u_irq (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .stat(stat_q), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[STAT_W-1:0];
      if (wr_ptr)  ptr_q  <= bus_wdata;
    end
  end

  // command byte: upper nibble to the command unit, low three bits to receive
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      vld_q <= wr_cmd;
      if (wr_cmd) begin
        cmd_q.cu <= bus_wdata[7:4];
        cmd_q.ru <= bus_wdata[2:0];
      end
    end
  end

  always_comb begin
    rdata_n = '0;
    if (rd_stat) rdata_n[STAT_MSB:STAT_LSB] = stat_q;
    if (rd_ptr)  rdata_n = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;
  assign cmd_vld   = vld_q;
  assign cu_op     = cmd_q.cu;
  assign ru_op     = cmd_q.ru;
  assign gen_ptr   = ptr_q;
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [STAT_W-1:0] evt_set,
  input logic [STAT_W-1:0] ctrl_q,
  input logic [STAT_W-1:0] stat_q,
  input logic              irq,
  input logic              cmd_vld,
  input logic [3:0]        cu_op,
  input logic [2:0]        ru_op
);
  logic cmd_hit, stat_hit;
  logic [STAT_W-1:0] live_set;
  assign cmd_hit  = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
  assign stat_hit = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign live_set = evt_set & STAT_IMPL;

  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTL_GMASK] |=> !irq);

  assert_swreq_fires_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTL_GMASK] && ctrl_q[CTL_SWREQ]) |=> irq);

  assert_event_fires_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTL_GMASK] && (|(stat_q[7:4] & ~ctrl_q[7:4]))) |=> irq);

  assert_event_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTL_GMASK] && !ctrl_q[CTL_SWREQ] &&
     !(|(stat_q[7:4] & ~ctrl_q[7:4]))) |=> !irq);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|live_set) |=> ((stat_q & $past(live_set)) == $past(live_set)));

  assert_clear_ones_R5: assert property (@(posedge clk) disable iff (rst)
    stat_hit |=> ((stat_q & $past(bus_wdata[15:8] & ~evt_set)) == '0));

  assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_hit |=> (cmd_vld && cu_op == $past(bus_wdata[7:4]) &&
                 ru_op == $past(bus_wdata[2:0])));

  assert_cmd_single_R3: assert property (@(posedge clk) disable iff (rst)
    !cmd_hit |=> !cmd_vld);
endmodule

bind hcr_top hcr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .evt_set(evt_set), .ctrl_q(ctrl_q),
  .stat_q(stat_q), .irq(irq), .cmd_vld(cmd_vld), .cu_op(cu_op),
  .ru_op(ru_op)
);

// File: tb/hcr_top_test.sv
`timescale 1ns/1ps
module hcr_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_set = '0;
  logic        irq, cmd_vld;
  logic [3:0]  cu_op;
  logic [2:0]  ru_op;
  logic [31:0] gen_ptr;

  int checks = 0;
  int errors = 0;

  // bench model of the registers
  logic [7:0]  m_ctrl = '0;
  logic [7:0]  m_stat = '0;
  logic [31:0] m_ptr  = '0;

  always #2 clk = ~clk;

  hcr_top uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .irq(irq), .cmd_vld(cmd_vld), .cu_op(cu_op),
    .ru_op(ru_op), .gen_ptr(gen_ptr)
  );

  function automatic logic model_irq(input logic [7:0] c, input logic [7:0] s);
    if (c[0])      return 1'b0;
    else if (c[1]) return 1'b1;
    else           return |(s[7:4] & ~c[7:4]);
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'd2)      return {16'h0, m_stat, 8'h0};
    else if (a == 8'd4) return m_ptr;
    else                return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, model update, check after the edge
  task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [31:0] d, input logic [7:0] ev);
    logic        e_irq;
    logic [31:0] e_rd;
    string       irq_req, rd_req;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_set = ev;
    e_irq   = model_irq(m_ctrl, m_stat);
    irq_req = m_ctrl[0] ? "R8" : (m_ctrl[1] ? "R9" : "R10");
    e_rd    = rd ? model_read(a) : 32'h0;
    rd_req  = (rd && a == 8'd2) ? "R4" : ((rd && a == 8'd4) ? "R2" : "R12");
    if (wr) begin
      case (a)
        8'd0: m_ctrl = d[7:0];
        8'd2: m_stat = m_stat & ~d[15:8];
        8'd4: m_ptr  = d;
        default: ;
      endcase
    end
    m_stat = m_stat | (ev & 8'hFD);   // R6 bit 1 reserved; R7 set after clear
    @(posedge clk);
    #1;
    check(irq === e_irq, irq_req, {31'h0, irq}, {31'h0, e_irq});
    check(bus_rdata === e_rd, rd_req, bus_rdata, e_rd);
    if (wr && a == 8'd1) begin
      check(cmd_vld === 1'b1, "R3", {31'h0, cmd_vld}, 32'h1);
      check(cu_op === d[7:4] && ru_op === d[2:0], "R3",
            {25'h0, cu_op, ru_op}, {25'h0, d[7:4], d[2:0]});
    end else begin
      check(cmd_vld === 1'b0, "R3", {31'h0, cmd_vld}, 32'h0);
    end
    bus_wr = 1'b0; bus_rd = 1'b0; evt_set = '0;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 8'h0, 32'h0, 8'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd5511);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state at the ports
    check(irq === 1'b0 && cmd_vld === 1'b0 && bus_rdata === 32'h0, "R1",
          {30'h0, irq, cmd_vld}, 32'h0);
    step(1'b0, 1'b1, 8'd2, 32'h0, 8'h0);
    check(bus_rdata === 32'h0, "R1", bus_rdata, 32'h0);
    step(1'b0, 1'b1, 8'd4, 32'h0, 8'h0);
    check(bus_rdata === 32'h0 && gen_ptr === 32'h0, "R1", bus_rdata, 32'h0);

    // R2 pointer round trip
    step(1'b1, 1'b0, 8'd4, 32'hDEADBEEF, 8'h0);
    step(1'b0, 1'b1, 8'd4, 32'h0, 8'h0);
    check(bus_rdata === 32'hDEADBEEF, "R2", bus_rdata, 32'hDEADBEEF);
    idle();
    check(bus_rdata === 32'h0, "R2", bus_rdata, 32'h0);

    // R3 command strobe; bit 3 ignored, one cycle only
    step(1'b1, 1'b0, 8'd1, 32'h000000AD, 8'h0);
    check(cu_op === 4'hA && ru_op === 3'h5, "R3", {25'h0, cu_op, ru_op},
          {25'h0, 4'hA, 3'h5});
    idle();
    check(cmd_vld === 1'b0, "R3", {31'h0, cmd_vld}, 32'h0);

    // mask everything while filling the status byte
    step(1'b1, 1'b0, 8'd0, 32'h000000F1, 8'h0);
    step(1'b0, 1'b0, 8'd0, 32'h0, 8'hFF);
    step(1'b0, 1'b1, 8'd2, 32'h0, 8'h0);
    check(bus_rdata === 32'h0000FD00, "R6", bus_rdata, 32'h0000FD00);
    check(irq === 1'b0, "R8", {31'h0, irq}, 32'h0);

    // R5 clear low nibble only
    step(1'b1, 1'b0, 8'd2, 32'h00000F00, 8'h0);
    step(1'b0, 1'b1, 8'd2, 32'h0, 8'h0);
    check(bus_rdata === 32'h0000F000, "R5", bus_rdata, 32'h0000F000);

    // R7 set wins over clear
    step(1'b1, 1'b0, 8'd2, 32'h0000FF00, 8'h80);
    step(1'b0, 1'b1, 8'd2, 32'h0, 8'h0);
    check(bus_rdata === 32'h00008000, "R7", bus_rdata, 32'h00008000);

    // R9 software request, status cleared, nothing enabled
    step(1'b1, 1'b0, 8'd2, 32'h0000FF00, 8'h0);
    step(1'b1, 1'b0, 8'd0, 32'h00000002, 8'h0);
    idle();
    check(irq === 1'b1, "R9", {31'h0, irq}, 32'h1);

    // R10 low status bits and control bit 3 raise nothing
    step(1'b1, 1'b0, 8'd0, 32'h00000008, 8'h0D);
    idle();
    idle();
    check(irq === 1'b0, "R10", {31'h0, irq}, 32'h0);

    // R11 two-edge latency from event pulse to irq
    step(1'b0, 1'b0, 8'd0, 32'h0, 8'h40);
    check(irq === 1'b0, "R11", {31'h0, irq}, 32'h0);
    idle();
    check(irq === 1'b1, "R11", {31'h0, irq}, 32'h1);

    // R10 per-event enable: mask bit 6 quiets the frame event
    step(1'b1, 1'b0, 8'd0, 32'h00000040, 8'h0);
    idle();
    check(irq === 1'b0, "R10", {31'h0, irq}, 32'h0);

    // R12 unmapped write and non-readable offsets
    step(1'b1, 1'b0, 8'd8, 32'h12345678, 8'h0);
    step(1'b1, 1'b0, 8'd5, 32'hFFFFFFFF, 8'h0);
    step(1'b0, 1'b1, 8'd4, 32'h0, 8'h0);
    check(bus_rdata === 32'hDEADBEEF, "R12", bus_rdata, 32'hDEADBEEF);
    step(1'b0, 1'b1, 8'd0, 32'h0, 8'h0);
    check(bus_rdata === 32'h0, "R12", bus_rdata, 32'h0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [7:0]  ev;
      int          kind;
      case ($urandom % 8)
        0: a = 8'd0; 1: a = 8'd1; 2: a = 8'd2; 3: a = 8'd3;
        4: a = 8'd4; 5: a = 8'd5; 6: a = 8'd6; default: a = 8'd8;
      endcase
      d    = $urandom;
      ev   = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
      kind = $urandom % 10;
      if (kind < 5)      step(1'b1, 1'b0, a, d, ev);
      else if (kind < 8) step(1'b0, 1'b1, a, 32'h0, ev);
      else               step(1'b0, 1'b0, a, 32'h0, ev);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule